// File: doc/BRIEF.md
# Parallel CRC engine

This block computes a cyclic redundancy check over a byte stream. On every clock edge where the valid strobe is high, it folds one whole data word into its state. The next state is a GF(2) linear function of the current state and the incoming word: each state bit is the XOR of a fixed subset of state bits and word bits. The subsets are worked out at elaboration from the generator polynomial, so a word of any supported width takes one combinational stage and one register.

The algorithm is fixed by parameters:

- the CRC width;
- the polynomial;
- the starting value;
- whether each input byte is bit-reversed before use;
- whether the final register is bit-reversed;
- the mask XORed onto the result.

A package supplies settings for six common 8-, 16- and 32-bit standards. The data word may be 8, 16, 32 or 64 bits wide. Within a word, the earliest stream byte occupies the top byte lane.

A frame starts by holding the active-low synchronous restart low for one clock. The words are then presented with the valid strobe high. The finished checksum is read from the output once the last word has been absorbed.

Top module: `crc_word_engine`

## Requirements
- R1: While rst_n is low at a rising clock edge, state_q loads INIT at that edge. A low rst_n between edges leaves state_q unchanged until the next edge.
- R2: With word_vld high at a rising edge, state_q after that edge equals the bit-serial CRC register after absorbing the word's bits most-significant first. The byte in bits [DATA_W-1:DATA_W-8] comes first in the stream.
- R3: With word_vld low at a rising edge, state_q keeps its value whatever word_in carries.
- R4: Words presented on consecutive valid cycles with no restart between them extend one running CRC. After each word, state_q matches the serial register over every byte absorbed so far.
- R5: crc_out equals state_q, bit-reversed across the full CRC width when REFLECT_OUT is 1, XORed with XOR_OUT. It follows state_q in the same cycle with no added register.
- R6: With REFLECT_IN set to 1, each byte lane of word_in is bit-reversed within its own eight bits before it is absorbed.
- R7: The CRC-32 setting gives crc_out 0xCBF43926 over the ASCII bytes "123456789". That setting is polynomial 0x04C11DB7, INIT and XOR_OUT 0xFFFFFFFF, with both reflections on.
- R8: Over "123456789" the other settings give these values:
  - CRC-32C (0x1EDC6F41, all-ones init and mask, reflected) gives 0xE3069283.
  - CRC-16/IBM (0x8005, zero init and mask, reflected) gives 0xBB3D.
  - CRC-16/MODBUS (0x8005, init 0xFFFF, zero mask, reflected) gives 0x4B37.
  - CRC-16/CCITT (0x1021, init 0xFFFF, zero mask, not reflected) gives 0x29B1.
  - CRC-8 (0x07, zero init and mask, not reflected) gives 0xF4.
- R9: For every setting and every DATA_W of 8, 16, 32 and 64, a 48-byte stream yields the same crc_out as a bit-serial model of that setting.
- R10: Holding rst_n low for one clock between two frames makes the second frame's result independent of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous restart; loads INIT |
| word_in | input | DATA_W | Data word, earliest byte in the top lane |
| word_vld | input | 1 | High to absorb word_in at this edge |
| state_q | output | CRC_W | Registered CRC state, unreflected and unmasked |
| crc_out | output | CRC_W | Final CRC: state_q, optionally reflected, XORed with XOR_OUT |

## Verification
- **When results are due.** A word on word_in is absorbed at the first rising edge where word_vld is high. state_q shows the result after that edge, and crc_out shows it in the same cycle, since it has no register of its own. A restart takes effect only at an edge.
- **How the bench keeps to that timing.** The bench drives word_in, word_vld and rst_n at falling edges. It checks state_q and crc_out at the following falling edge, after exactly one register stage. For the between-edges restart check, it samples one nanosecond after rst_n falls and again at the next falling edge.
- **Reference model.** Expected values come from a separate serial model in the bench. For reflected settings the model shifts right with a mirrored polynomial, so it does not mirror the engine's matrix construction.

// File: rtl/crc_pkg.sv
package crc_pkg;

   typedef struct packed {
      int         width;
      logic [63:0] poly;
      logic [63:0] init;
      logic [63:0] xout;
      logic        rin;
      logic        rout;
   } crc_cfg_t;

   localparam int N_PRESETS = 6;

   // 0 CRC-32, 1 CRC-32C, 2 CRC-16/IBM, 3 CRC-16/MODBUS, 4 CRC-16/CCITT, 5 CRC-8
   function automatic crc_cfg_t crc_preset(input int idx);
      crc_cfg_t c;
      case (idx)
         0:       c = '{32, 64'h04C11DB7, 64'hFFFFFFFF, 64'hFFFFFFFF, 1'b1, 1'b1};
         1:       c = '{32, 64'h1EDC6F41, 64'hFFFFFFFF, 64'hFFFFFFFF, 1'b1, 1'b1};
         2:       c = '{16, 64'h8005,     64'h0,        64'h0,        1'b1, 1'b1};
         3:       c = '{16, 64'h8005,     64'hFFFF,     64'h0,        1'b1, 1'b1};
         4:       c = '{16, 64'h1021,     64'hFFFF,     64'h0,        1'b0, 1'b0};
         default: c = '{8,  64'h07,       64'h0,        64'h0,        1'b0, 1'b0};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/crc_bit_mirror.sv
module crc_bit_mirror #(
   parameter int W     = 32,
   parameter int CHUNK = 8,
   parameter bit EN    = 1'b1
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int N_CHUNK = W / CHUNK;

   generate
      if (EN) begin : g_swap
         for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
            for (genvar b = 0; b < CHUNK; b++) begin : g_bit
               assign dout[c*CHUNK + b] = din[c*CHUNK + CHUNK - 1 - b];
            end
         end
      end else begin : g_pass
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/crc_xor_net.sv
module crc_xor_net #(
   parameter int              CRC_W  = 32,
   parameter int              DATA_W = 32,
   parameter logic [CRC_W-1:0] POLY  = 32'h04C11DB7
) (
   input  logic [CRC_W-1:0]  st,
   input  logic [DATA_W-1:0] wd,
   output logic [CRC_W-1:0]  nxt
);
   // Serial reference fold, used only to derive constant row masks.
   function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c,
                                              input logic [DATA_W-1:0] d);
      logic [CRC_W-1:0] r;
      logic             fb;
      r = c;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb = r[CRC_W-1] ^ d[i];
         r  = {r[CRC_W-2:0], 1'b0};
         if (fb) r = r ^ POLY;
      end
      return r;
   endfunction

   // Which state bits feed output bit j (row j of the transition matrix).
   function automatic logic [CRC_W-1:0] a_row(input int j);
      logic [CRC_W-1:0] row;
      logic [CRC_W-1:0] e;
      logic [CRC_W-1:0] col;
      row = '0;
      for (int k = 0; k < CRC_W; k++) begin
         e      = '0;
         e[k]   = 1'b1;
         col    = fold(e, '0);
         row[k] = col[j];
      end
      return row;
   endfunction

   // Which word bits feed output bit j (row j of the injection matrix).
   function automatic logic [DATA_W-1:0] b_row(input int j);
      logic [DATA_W-1:0] row;
      logic [DATA_W-1:0] e;
      logic [CRC_W-1:0]  col;
      row = '0;
      for (int k = 0; k < DATA_W; k++) begin
         e      = '0;
         e[k]   = 1'b1;
         col    = fold('0, e);
         row[k] = col[j];
      end
      return row;
   endfunction

   generate
      for (genvar j = 0; j < CRC_W; j++) begin : g_row
         localparam logic [CRC_W-1:0]  AR = a_row(j);
         localparam logic [DATA_W-1:0] BR = b_row(j);
         assign nxt[j] = (^(st & AR)) ^ (^(wd & BR));
      end
   endgenerate
endmodule

// File: rtl/crc_word_engine.sv
module crc_word_engine #(
   parameter int               CRC_W       = 32,
   parameter int               DATA_W      = 32,
   parameter logic [CRC_W-1:0] POLY        = 32'h04C11DB7,
   parameter logic [CRC_W-1:0] INIT        = 32'hFFFFFFFF,
   parameter logic [CRC_W-1:0] XOR_OUT     = 32'hFFFFFFFF,
   parameter bit               REFLECT_IN  = 1'b1,
   parameter bit               REFLECT_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] word_in,
   input  logic              word_vld,
   output logic [CRC_W-1:0]  state_q,
   output logic [CRC_W-1:0]  crc_out
);
   logic [DATA_W-1:0] word_ord;
   logic [CRC_W-1:0]  state_nxt;
   logic [CRC_W-1:0]  state_mir;

   crc_bit_mirror #(.W(DATA_W), .CHUNK(8), .EN(REFLECT_IN)) u_in_mir (
      .din  (word_in),
      .dout (word_ord)
   );

   crc_xor_net #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_net (
      .st  (state_q),
      .wd  (word_ord),
      .nxt (state_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        state_q <= INIT;
      else if (word_vld) state_q <= state_nxt;
   end

   crc_bit_mirror #(.W(CRC_W), .CHUNK(CRC_W), .EN(REFLECT_OUT)) u_out_mir (
      .din  (state_q),
      .dout (state_mir)
   );

   assign crc_out = state_mir ^ XOR_OUT;
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
   parameter int               CRC_W  = 32,
   parameter int               DATA_W = 32,
   parameter logic [CRC_W-1:0] INIT   = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] word_in,
   input logic              word_vld,
   input logic [CRC_W-1:0]  state_q,
   input logic [CRC_W-1:0]  crc_out
);
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   // R1
   reset_init_chk: assert property (@(posedge clk) disable iff (!armed)
      !rst_n |=> state_q == INIT);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |=> $stable(state_q));

   // R2
   zero_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && word_in == '0 && state_q == '0) |=> state_q == '0);

   // R5
   out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(state_q) |-> $stable(crc_out));
endmodule

bind crc_word_engine crc_engine_chk #(.CRC_W(CRC_W), .DATA_W(DATA_W), .INIT(INIT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .word_in  (word_in),
   .word_vld (word_vld),
   .state_q  (state_q),
   .crc_out  (crc_out)
);

// File: tb/sim_crc_word_engine.sv
`timescale 1ns/1ps
module sim_crc_word_engine;
   import crc_pkg::*;

   logic        clk = 1'b0;
   logic        rstn = 1'b0;
   logic [63:0] wdat [0:3];
   logic        wvld [0:3];
   logic [63:0] st_a  [0:N_PRESETS-1][0:3];
   logic [63:0] out_a [0:N_PRESETS-1][0:3];
   logic [7:0]  msg  [0:47];
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   generate
      for (genvar gp = 0; gp < N_PRESETS; gp++) begin : g_p
         for (genvar gw = 0; gw < 4; gw++) begin : g_w
            localparam crc_cfg_t CFG = crc_preset(gp);
            localparam int CW = CFG.width;
            localparam int DW = 8 << gw;
            logic [CW-1:0] st;
            logic [CW-1:0] fo;
            crc_word_engine #(
               .CRC_W(CW), .DATA_W(DW),
               .POLY(CFG.poly[CW-1:0]), .INIT(CFG.init[CW-1:0]),
               .XOR_OUT(CFG.xout[CW-1:0]),
               .REFLECT_IN(CFG.rin), .REFLECT_OUT(CFG.rout)
            ) u0 (
               .clk(clk), .rst_n(rstn), .word_in(wdat[gw][DW-1:0]),
               .word_vld(wvld[gw]), .state_q(st), .crc_out(fo)
            );
            assign st_a[gp][gw]  = 64'(st);
            assign out_a[gp][gw] = 64'(fo);
         end
      end
   endgenerate

   typedef struct packed {
      int          p;
      logic [63:0] exp;
   } vec_t;
   localparam vec_t VEC [0:5] = '{
      '{0, 64'hCBF43926}, '{1, 64'hE3069283}, '{2, 64'hBB3D},
      '{3, 64'h4B37},     '{4, 64'h29B1},     '{5, 64'hF4}
   };

   function automatic logic [63:0] refl(input logic [63:0] v, input int w);
      logic [63:0] r = '0;
      for (int i = 0; i < w; i++) r[w-1-i] = v[i];
      return r;
   endfunction

   // Serial model; returns the register in the engine's unreflected convention.
   function automatic logic [63:0] ref_state(input int p, input int n);
      crc_cfg_t    c = crc_preset(p);
      int          w = c.width;
      logic [63:0] mask = (64'd1 << w) - 64'd1;
      logic [63:0] r;
      logic [63:0] rp;
      if (c.rin) begin
         r  = refl(c.init, w);
         rp = refl(c.poly, w);
         for (int b = 0; b < n; b++) begin
            r = r ^ {56'd0, msg[b]};
            for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ rp) : (r >> 1);
         end
         return refl(r, w);
      end
      r = c.init;
      for (int b = 0; b < n; b++) begin
         r = r ^ ({56'd0, msg[b]} << (w - 8));
         for (int i = 0; i < 8; i++)
            r = r[w-1] ? (((r << 1) ^ c.poly) & mask) : ((r << 1) & mask);
      end
      return r;
   endfunction

   function automatic logic [63:0] ref_crc(input int p, input int n);
      crc_cfg_t c = crc_preset(p);
      logic [63:0] s = ref_state(p, n);
      return (c.rout ? refl(s, c.width) : s) ^ c.xout;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic restart();
      @(negedge clk); rstn = 1'b0;
      @(negedge clk); rstn = 1'b1;
   endtask

   task automatic drive(input int wi, input int k);
      int          nb = 1 << wi;
      logic [63:0] v = '0;
      for (int i = 0; i < nb; i++) v[(nb-1-i)*8 +: 8] = msg[k*nb + i];
      wdat[wi] = v;
      wvld[wi] = 1'b1;
   endtask

   // Stream n bytes into width lane wi; check running state after every word.
   task automatic send(input int wi, input int n, input string tag);
      int nb = 1 << wi;
      int nw = n / nb;
      drive(wi, 0);
      for (int k = 0; k < nw; k++) begin
         @(negedge clk);
         if (k + 1 < nw) drive(wi, k + 1);
         else            wvld[wi] = 1'b0;
         for (int p = 0; p < N_PRESETS; p++)
            chk(tag, st_a[p][wi], ref_state(p, (k + 1) * nb));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] s;
      for (int i = 0; i < 4; i++) begin wdat[i] = '0; wvld[i] = 1'b0; end
      for (int i = 0; i < 48; i++) msg[i] = 8'h00;
      repeat (2) @(negedge clk);
      rstn = 1'b1;

      // R1 reset state, R5 output mapping of INIT
      for (int p = 0; p < N_PRESETS; p++)
         for (int wi = 0; wi < 4; wi++) begin
            chk("R1 reset state", st_a[p][wi], crc_preset(p).init);
            chk("R5 reset output", out_a[p][wi], ref_crc(p, 0));
         end

      // R7 R8 R6 check values over "123456789", 8-bit lane, R2 per word
      for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
      @(negedge clk);
      send(0, 9, "R2 byte fold");
      for (int v = 0; v < 6; v++) begin
         if (v == 0) chk("R7 CRC-32 check", out_a[VEC[v].p][0], VEC[v].exp);
         else if (crc_preset(VEC[v].p).rin)
            chk("R8 R6 reflected check", out_a[VEC[v].p][0], VEC[v].exp);
         else chk("R8 plain check", out_a[VEC[v].p][0], VEC[v].exp);
      end

      // R3 idle words ignored
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         for (int wi = 0; wi < 4; wi++) wdat[wi] = {16{4'(c + 5)}};
      end
      @(negedge clk);
      for (int p = 0; p < N_PRESETS; p++) chk("R3 hold", st_a[p][0], ref_state(p, 9));

      // R1 synchronous: no effect between edges, INIT after the edge
      @(negedge clk); rstn = 1'b0;
      #1;
      for (int p = 0; p < N_PRESETS; p++) chk("R1 no async", st_a[p][0], ref_state(p, 9));
      @(negedge clk);
      for (int p = 0; p < N_PRESETS; p++) chk("R1 sync load", st_a[p][0], crc_preset(p).init);
      rstn = 1'b1;

      // R4 R9 random 48-byte stream on every width
      s = 32'h1234ABCD;
      for (int i = 0; i < 48; i++) begin
         s ^= s << 13; s ^= s >> 17; s ^= s << 5;
         msg[i] = s[7:0];
      end
      restart();
      for (int wi = 0; wi < 4; wi++) send(wi, 48, "R4 running");
      for (int p = 0; p < N_PRESETS; p++)
         for (int wi = 0; wi < 4; wi++) chk("R9 width match", out_a[p][wi], ref_crc(p, 48));

      // R10 restart then new frame
      for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
      restart();
      send(0, 9, "R10 frame state");
      chk("R10 new frame", out_a[0][0], 64'hCBF43926);
      chk("R10 new frame", out_a[4][0], 64'h29B1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule